// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block sits beside a two-port RAM with a 14-bit address space and turns the two highest words of that space into mailboxes. Port A (the left side) and port B (the right side) each present an active-low enable, an active-low write strobe, an active-low output enable and an address. The block watches both ports and keeps one pending-message flag per port. The RAM array stores the mailbox words. Their meaning is left to software, and this block never touches the data.

Port B's mailbox is the very top word, `0x3FFF`, and port A's mailbox is the word below it, `0x3FFE`. When a port writes its partner's mailbox, the partner's interrupt output goes low. When the partner reads its own mailbox, that output returns high. Each flag is a register, so it changes one clock edge after the access that moves it. The interface carries no data stream, so every pin is a plain level with no valid/ready handshake.

Top module: `mbx_irq_flags`

## Requirements
- R1: While reset is asserted and on the first edge after it is released, both `a_irq_n` and `b_irq_n` are high (no message pending).
- R2: A port A write to `0x3FFF` drives `b_irq_n` low after the next rising clock edge.
- R3: A port B read of `0x3FFF` drives `b_irq_n` high after the next rising clock edge, unless a set of the same flag happens in that cycle.
- R4: A port B write to `0x3FFE` drives `a_irq_n` low after the next rising clock edge.
- R5: A port A read of `0x3FFE` drives `a_irq_n` high after the next rising clock edge, unless a set of the same flag happens in that cycle.
- R6: A port writes only when both its enable (`*_en_n`) and its write strobe (`*_we_n`) are 0. A write strobe low with the enable high changes no flag.
- R7: A port reads only when its enable and output enable (`*_oe_n`) are 0 and its write strobe is 1. An access with the output enable high, or with the write strobe low, clears no flag.
- R8: When a set and a clear of the same flag happen in one cycle, the flag is pending after the edge, so no message is lost.
- R9: Accesses to any other address, a port writing its own mailbox, and a port reading its partner's mailbox change no flag.
- R10: In a cycle with no set and no clear of a flag, that flag keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both flag registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_en_n | input | 1 | Port A enable, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | 14 | Port A word address |
| b_en_n | input | 1 | Port B enable, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | 14 | Port B word address |
| a_irq_n | output | 1 | Message pending for port A, active low, always driven |
| b_irq_n | output | 1 | Message pending for port B, active low, always driven |

## Verification
The bench sends a write and a read to the same flag in a single cycle, both while the flag is clear and while it is already set. A design that gives the clear priority would lose the message and leave the output high. It also makes near-miss accesses: a write strobe with the enable off, a read with the output enable off, a port writing its own mailbox, a port reading its partner's mailbox, and a neighbouring address. A decoder that ignores the enable, treats a write as a read, or swaps the two mailbox addresses would move a flag on one of these. Idle cycles between events check that a flag holds its value, and a double set checks that the two flags are independent.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic en_n;
    logic we_n;
    logic oe_n;
  } port_ctl_t;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Write: enable and strobe low. Read: enable and output enable low, strobe high.
  function automatic acc_kind_t classify(port_ctl_t c);
    acc_kind_t k;
    k = ACC_IDLE;
    if (!c.en_n) begin
      if (!c.we_n)      k = ACC_WRITE;
      else if (!c.oe_n) k = ACC_READ;
    end
    return k;
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] NOTIFY_ADDR = '1,
  parameter logic [ADDR_W-1:0] ACK_ADDR = '0
) (
  input  port_ctl_t         ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              notify,
  output logic              ack
);

  acc_kind_t kind;

  always_comb begin
    kind   = classify(ctl);
    notify = (kind == ACC_WRITE) && (addr == NOTIFY_ADDR);
    ack    = (kind == ACC_READ) && (addr == ACK_ADDR);
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);

  logic pending_q;
  logic pending_d;

  // A set in the same cycle as a clear wins.
  always_comb begin
    pending_d = pending_q;
    if (clr_req) pending_d = 1'b0;
    if (set_req) pending_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= pending_d;
  end

  assign irq_n = ~pending_q;

endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_irq_n,
  output logic              b_irq_n
);

  localparam int NPORT = 2;
  // Port B's box is the top word, port A's box the word below it.
  localparam logic [ADDR_W-1:0] BOX_B = '1;
  localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};

  port_ctl_t         ctl   [NPORT];
  logic [ADDR_W-1:0] addr  [NPORT];
  logic [NPORT-1:0]  notify;
  logic [NPORT-1:0]  ack;
  logic [NPORT-1:0]  irq_n;

  assign ctl[0]  = '{en_n: a_en_n, we_n: a_we_n, oe_n: a_oe_n};
  assign ctl[1]  = '{en_n: b_en_n, we_n: b_we_n, oe_n: b_oe_n};
  assign addr[0] = a_addr;
  assign addr[1] = b_addr;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam logic [ADDR_W-1:0] PEER_BOX = (i == 0) ? BOX_B : BOX_A;
    localparam logic [ADDR_W-1:0] OWN_BOX  = (i == 0) ? BOX_A : BOX_B;

    mbx_port_decode #(
      .ADDR_W     (ADDR_W),
      .NOTIFY_ADDR(PEER_BOX),
      .ACK_ADDR   (OWN_BOX)
    ) u_dec (
      .ctl   (ctl[i]),
      .addr  (addr[i]),
      .notify(notify[i]),
      .ack   (ack[i])
    );

    mbx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(notify[NPORT-1-i]),
      .clr_req(ack[i]),
      .irq_n  (irq_n[i])
    );
  end

  assign a_irq_n = irq_n[0];
  assign b_irq_n = irq_n[1];

endmodule

// File: rtl/mbx_irq_flags_chk.sv
module mbx_irq_flags_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_en_n,
  input logic              a_we_n,
  input logic              a_oe_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_en_n,
  input logic              b_we_n,
  input logic              b_oe_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_irq_n,
  input logic              b_irq_n
);

  localparam logic [ADDR_W-1:0] TOP_WORD  = '1;
  localparam logic [ADDR_W-1:0] NEXT_WORD = TOP_WORD - 1'b1;

  logic a_wr, a_rd, b_wr, b_rd;
  logic set_a, clr_a, set_b, clr_b;

  always_comb begin
    a_wr  = (a_en_n == 1'b0) && (a_we_n == 1'b0);
    a_rd  = (a_en_n == 1'b0) && (a_oe_n == 1'b0) && (a_we_n == 1'b1);
    b_wr  = (b_en_n == 1'b0) && (b_we_n == 1'b0);
    b_rd  = (b_en_n == 1'b0) && (b_oe_n == 1'b0) && (b_we_n == 1'b1);
    set_b = a_wr && (a_addr == TOP_WORD);
    clr_b = b_rd && (b_addr == TOP_WORD);
    set_a = b_wr && (b_addr == NEXT_WORD);
    clr_a = a_rd && (a_addr == NEXT_WORD);
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (a_irq_n && b_irq_n));

  // Set wins over a same-cycle clear (R8).
  p_set_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_b |=> !b_irq_n);

  p_clr_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_b && !set_b) |=> b_irq_n);

  p_set_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_a |=> !a_irq_n);

  p_clr_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a && !set_a) |=> a_irq_n);

  p_hold_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_a || clr_a) |=> $stable(a_irq_n));

  p_hold_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_b || clr_b) |=> $stable(b_irq_n));

endmodule

bind mbx_irq_flags mbx_irq_flags_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_en_n (a_en_n),
  .a_we_n (a_we_n),
  .a_oe_n (a_oe_n),
  .a_addr (a_addr),
  .b_en_n (b_en_n),
  .b_we_n (b_we_n),
  .b_oe_n (b_oe_n),
  .b_addr (b_addr),
  .a_irq_n(a_irq_n),
  .b_irq_n(b_irq_n)
);

// File: tb/mbx_irq_flags_bench.sv
`timescale 1ns/1ps
module mbx_irq_flags_bench;

  localparam int AW = 14;
  localparam logic [AW-1:0] TOP  = 14'h3FFF;
  localparam logic [AW-1:0] NEXT = 14'h3FFE;
  localparam logic [AW-1:0] OTHR = 14'h3FFD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_en_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic          b_en_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic          a_irq_n, b_irq_n;

  int checks = 0;
  int errors = 0;
  logic model_a = 1'b0;
  logic model_b = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbx_irq_flags #(.ADDR_W(AW)) u_mbx_irq_flags (
    .clk(clk), .rst_n(rst_n),
    .a_en_n(a_en_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .b_en_n(b_en_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
  );

  task automatic compare(input logic [1:0] exp, input string tag);
    checks++;
    if ({a_irq_n, b_irq_n} !== exp) begin
      errors++;
      $display("FAIL %s: a_irq_n,b_irq_n=%b%b expected %b", tag, a_irq_n, b_irq_n, exp);
    end
  endtask

  // One cycle of stimulus on both ports; the expected outputs after the edge
  // are computed from the requirements and queued for the monitor.
  task automatic drive(input logic aen, input logic awe, input logic aoe, input logic [AW-1:0] aad,
                       input logic ben, input logic bwe, input logic boe, input logic [AW-1:0] bad,
                       input string tag);
    logic awr, ard, bwr, brd;
    @(negedge clk);
    a_en_n = aen; a_we_n = awe; a_oe_n = aoe; a_addr = aad;
    b_en_n = ben; b_we_n = bwe; b_oe_n = boe; b_addr = bad;
    awr = !aen && !awe;
    ard = !aen && !aoe && awe;
    bwr = !ben && !bwe;
    brd = !ben && !boe && bwe;
    model_b = (awr && aad == TOP)  || (model_b && !(brd && bad == TOP));
    model_a = (bwr && bad == NEXT) || (model_a && !(ard && aad == NEXT));
    exp_q.push_back({~model_a, ~model_b});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1, 1, 1, '0, 1, 1, 1, '0, tag);
  endtask

  // Monitor: sample 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compare(e, t);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compare(2'b11, "R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    idle("R1 after release");
    idle("R10 idle");
    // R2 then hold (R10) then R3
    drive(0, 0, 1, TOP, 1, 1, 1, '0, "R2 A writes 3FFF");
    idle("R10 hold b set");
    drive(1, 1, 1, '0, 0, 1, 0, TOP, "R3 B reads 3FFF");
    // R4 then R5
    drive(1, 1, 1, '0, 0, 0, 1, NEXT, "R4 B writes 3FFE");
    idle("R10 hold a set");
    drive(0, 1, 0, NEXT, 1, 1, 1, '0, "R5 A reads 3FFE");
    // R6: strobe without enable
    drive(1, 0, 1, TOP, 1, 0, 1, NEXT, "R6 strobes with enable high");
    // R9: other address, own box writes
    drive(0, 0, 1, OTHR, 0, 0, 1, OTHR, "R9 writes to 3FFD");
    drive(0, 0, 1, NEXT, 0, 0, 1, TOP, "R9 ports write own boxes");
    // R7: reads that are not reads
    drive(0, 0, 1, TOP, 1, 1, 1, '0, "R2 set b again");
    drive(1, 1, 1, '0, 0, 1, 1, TOP, "R7 B read with oe high");
    drive(1, 1, 1, '0, 0, 0, 0, TOP, "R7 B write strobe low at 3FFF");
    drive(0, 1, 0, TOP, 1, 1, 1, '0, "R9 A reads 3FFF");
    drive(1, 1, 1, '0, 0, 1, 0, NEXT, "R9 B reads 3FFE");
    drive(1, 1, 1, '0, 1, 1, 0, TOP, "R7 B read with enable high");
    drive(1, 1, 1, '0, 0, 1, 0, TOP, "R3 B reads 3FFF again");
    // R8: same-cycle set and clear, flag clear then set
    drive(0, 0, 1, TOP, 0, 1, 0, TOP, "R8 b set+clear from clear");
    drive(0, 0, 1, TOP, 0, 1, 0, TOP, "R8 b set+clear from set");
    drive(0, 1, 0, NEXT, 0, 0, 1, NEXT, "R8 a set+clear from clear");
    drive(0, 1, 0, NEXT, 0, 1, 0, TOP, "R5 R3 both cleared");
    // Both flags set at once
    drive(0, 0, 1, TOP, 0, 0, 1, NEXT, "R2 R4 both set");
    idle("R10 both held");
    drive(0, 1, 0, NEXT, 1, 1, 1, '0, "R5 only a cleared");
    drive(1, 1, 1, '0, 0, 1, 0, TOP, "R3 only b cleared");
    idle("R10 final idle");
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule